// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches a bank of asynchronous external interrupt pins. It turns activity on each pin into a pending flag, and presents the flags to a parent interrupt controller on a small number of summary lines. Each pin first goes through a synchroniser. It is then compared against a trigger condition chosen by software: active-low level, active-high level, falling edge, rising edge or either edge. A hit records the pin in a pending register.

A mask register decides which pending flags may drive the summary lines. Each summary line is the OR of unmasked pending flags over a fixed group of pins. The first group is smaller than the others.

Software uses a four-word register port to program the triggers, set the mask, and read or clear the pending flags. Reads are combinational. Writes take effect at the next clock edge. Two adjacent pins share one trigger field, so a configuration word of width W carries W/4 fields and covers 2·W/4 pins.

Top module: `eint_group_ctrl`

## Requirements
- R1: Only pins 0 to NUM_INPUTS-1 (0 to 27 by default) exist. Mask and pending bits at or above NUM_INPUTS ignore writes and read as 0.
- R2: Word index 0 holds the trigger fields for pins 0–15 and word index 1 holds those for pins 16–27. Only the 3-bit fields are stored. Bit 3 of every 4-bit slot, and every slot past the last pin, reads as 0, so writing all ones returns 0x77777777 from word 0 and 0x00777777 from word 1.
- R3: Pin n uses the 3-bit field at bit (k/2)*4 of its word, where k is n minus the first pin of that word. Pins 2j and 2j+1 share one field.
- R4: Field code 000 selects active-low level and 001 selects active-high level.
- R5: Field codes 01x select falling edge, 10x select rising edge and 11x select both edges. An edge sets the pending flag once.
- R6: A pin change shows up in the pending register after the third rising clock edge that follows it: two synchroniser stages, then the pending update.
- R7: While a level-triggered pin holds its active level, its pending flag is set again every cycle. A clear only sticks once the level has gone.
- R8: The pending register is at word index 3. Writing 1 to bit n clears flag n and writing 0 leaves it. A new hit in the same cycle as a clear wins.
- R9: The mask is at word index 2. Mask bit n = 1 keeps pin n off the summary lines, but flag n is still recorded.
- R10: The four summary lines are the OR of pending-and-unmasked flags over pins 0–3, 4–11, 12–19 and 20–27.
- R11: A read of the pending register returns the raw flags, whatever the mask holds.
- R12: After reset, the pending flags and all trigger fields are 0 and every valid mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_INPUTS | Asynchronous external interrupt pins |
| bus_we_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | ADDR_W | Word index: 0 trigger low, 1 trigger high, 2 mask, 3 pending |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| irq_o | output | NUM_GROUPS | Summary lines to the parent controller |

## Verification
The bench builds the block with its default parameters: 28 pins, a two-stage synchroniser, groups of 4/8/8/8 and 32-bit words. With these values the upper configuration word is only partly filled, and the four unused top bits of mask and pending can be probed. Random pin activity runs under configuration words that use every trigger code, together with random clears and mask changes. Directed sequences cover the synchroniser latency, a level that re-arms after a clear, and a clear that collides with a hit.

// File: rtl/eint_pkg.sv
package eint_pkg;
   localparam int FIELD_W      = 3;
   localparam int FIELD_STRIDE = 4;

   typedef enum logic [1:0] {
      REG_CFG_LO = 2'd0,
      REG_CFG_HI = 2'd1,
      REG_MASK   = 2'd2,
      REG_PEND   = 2'd3
   } eint_reg_e;

   // trigger evaluation on the synchronised level and its previous sample
   function automatic logic trig_hit(input logic [FIELD_W-1:0] code,
                                     input logic cur, input logic prev);
      logic r;
      unique casez (code)
         3'b000:  r = ~cur;
         3'b001:  r = cur;
         3'b01?:  r = prev & ~cur;
         3'b10?:  r = ~prev & cur;
         default: r = prev ^ cur;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
   parameter int WIDTH  = 28,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= async_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];

   logic [2:0] warm_q;
   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                  warm_q <= '0;
      else if (warm_q < 3'(STAGES)) warm_q <= warm_q + 3'd1;

   assert_sync_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 3'(STAGES)) |-> (sync_o == $past(async_i, STAGES)));
endmodule

// File: rtl/eint_detect.sv
module eint_detect import eint_pkg::*; #(
   parameter int WIDTH = 28
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [WIDTH-1:0]         sig_i,
   input  logic [WIDTH*FIELD_W-1:0] code_i,
   output logic [WIDTH-1:0]         hit_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= sig_i;

   for (genvar n = 0; n < WIDTH; n++) begin : g_pin
      assign hit_o[n] = trig_hit(code_i[n*FIELD_W +: FIELD_W], sig_i[n], prev_q[n]);

      assert_rise_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (code_i[n*FIELD_W +: 2] == 2'b00 && code_i[n*FIELD_W+2] == 1'b1 && code_i[n*FIELD_W+1] == 1'b0)
            |-> (hit_o[n] == (sig_i[n] && !$past(sig_i[n]))));
      assert_level_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (code_i[n*FIELD_W +: FIELD_W] == 3'b001 && $stable(sig_i[n]) && sig_i[n]) |-> hit_o[n]);
   end
endmodule

// File: rtl/eint_merge.sv
module eint_merge #(
   parameter int NUM_INPUTS  = 28,
   parameter int FIRST_GROUP = 4,
   parameter int GROUP_SIZE  = 8,
   parameter int NUM_GROUPS  = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_INPUTS-1:0] active_i,
   output logic [NUM_GROUPS-1:0] irq_o
);
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int LO = (g == 0) ? 0 : FIRST_GROUP + (g - 1) * GROUP_SIZE;
      localparam int HI = (g == 0) ? FIRST_GROUP - 1 : LO + GROUP_SIZE - 1;
      assign irq_o[g] = |active_i[HI:LO];
   end

   assert_quiet_groups_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i == '0) |-> (irq_o == '0));
   assert_any_group_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i != '0) |-> (irq_o != '0));
endmodule

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl import eint_pkg::*; #(
   parameter int NUM_INPUTS  = 28,
   parameter int SYNC_STAGES = 2,
   parameter int FIRST_GROUP = 4,
   parameter int GROUP_SIZE  = 8,
   parameter int NUM_GROUPS  = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_INPUTS-1:0] pins_i,
   input  logic                  bus_we_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [DATA_W-1:0]     bus_wdata_i,
   output logic [DATA_W-1:0]     bus_rdata_o,
   output logic [NUM_GROUPS-1:0] irq_o
);
   localparam int FIELDS_PER_REG = DATA_W / FIELD_STRIDE;
   localparam int INPUTS_PER_REG = 2 * FIELDS_PER_REG;
   localparam int NUM_FIELDS     = NUM_INPUTS / 2;
   localparam logic [NUM_INPUTS-1:0] ALL_IN = '1;

   // elaboration-time parameter checks
   if (NUM_INPUTS % 2 != 0 || NUM_INPUTS <= INPUTS_PER_REG || NUM_INPUTS > 2 * INPUTS_PER_REG)
   begin : g_bad_inputs
      $error("eint_group_ctrl: NUM_INPUTS must be even and fit the two trigger words");
   end
   if (NUM_INPUTS > DATA_W) begin : g_bad_width
      $error("eint_group_ctrl: NUM_INPUTS exceeds DATA_W");
   end
   if (FIRST_GROUP + (NUM_GROUPS - 1) * GROUP_SIZE != NUM_INPUTS) begin : g_bad_groups
      $error("eint_group_ctrl: group sizes do not cover NUM_INPUTS");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("eint_group_ctrl: SYNC_STAGES must be 2..4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("eint_group_ctrl: ADDR_W must be at least 2");
   end

   logic wr_lo, wr_hi, wr_mask, wr_pend;
   assign wr_lo   = bus_we_i && (bus_addr_i == ADDR_W'(REG_CFG_LO));
   assign wr_hi   = bus_we_i && (bus_addr_i == ADDR_W'(REG_CFG_HI));
   assign wr_mask = bus_we_i && (bus_addr_i == ADDR_W'(REG_MASK));
   assign wr_pend = bus_we_i && (bus_addr_i == ADDR_W'(REG_PEND));

   // trigger fields, one per pin pair
   logic [FIELD_W-1:0] field_q [NUM_FIELDS];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam bit IN_LO = (f < FIELDS_PER_REG);
      localparam int OFS   = (f % FIELDS_PER_REG) * FIELD_STRIDE;
      logic wr_this;
      assign wr_this = IN_LO ? wr_lo : wr_hi;
      always_ff @(posedge clk_i or negedge rst_ni)
         if (!rst_ni)      field_q[f] <= '0;
         else if (wr_this) field_q[f] <= bus_wdata_i[OFS +: FIELD_W];
   end

   logic [NUM_INPUTS*FIELD_W-1:0] code_flat;
   for (genvar n = 0; n < NUM_INPUTS; n++) begin : g_code
      assign code_flat[n*FIELD_W +: FIELD_W] = field_q[n/2];
   end

   logic [NUM_INPUTS-1:0] sync_w, hit_w;

   eint_sync #(.WIDTH(NUM_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pins_i), .sync_o(sync_w));

   eint_detect #(.WIDTH(NUM_INPUTS)) u_detect (
      .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sync_w), .code_i(code_flat), .hit_o(hit_w));

   // mask and pending state
   logic [NUM_INPUTS-1:0] mask_q, pend_q, clr_w;
   assign clr_w = wr_pend ? bus_wdata_i[NUM_INPUTS-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
         mask_q <= ALL_IN;
         pend_q <= '0;
      end else begin
         if (wr_mask) mask_q <= bus_wdata_i[NUM_INPUTS-1:0];
         pend_q <= (pend_q & ~clr_w) | hit_w;
      end

   eint_merge #(.NUM_INPUTS(NUM_INPUTS), .FIRST_GROUP(FIRST_GROUP),
                .GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS)) u_merge (
      .clk_i(clk_i), .rst_ni(rst_ni), .active_i(pend_q & ~mask_q), .irq_o(irq_o));

   // register readback
   logic [DATA_W-1:0] cfg_lo_word, cfg_hi_word;
   always_comb begin
      cfg_lo_word = '0;
      cfg_hi_word = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (f < FIELDS_PER_REG)
            cfg_lo_word[f*FIELD_STRIDE +: FIELD_W] = field_q[f];
         else
            cfg_hi_word[(f-FIELDS_PER_REG)*FIELD_STRIDE +: FIELD_W] = field_q[f];
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(REG_CFG_LO))      bus_rdata_o = cfg_lo_word;
      else if (bus_addr_i == ADDR_W'(REG_CFG_HI)) bus_rdata_o = cfg_hi_word;
      else if (bus_addr_i == ADDR_W'(REG_MASK))   bus_rdata_o = DATA_W'(mask_q);
      else if (bus_addr_i == ADDR_W'(REG_PEND))   bus_rdata_o = DATA_W'(pend_q);
   end

   // assertions
   assert_hit_recorded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_w != '0) |=> ((pend_q & $past(hit_w)) == $past(hit_w)));
   assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_pend |=> ((pend_q & $past(bus_wdata_i[NUM_INPUTS-1:0] & ~hit_w)) == '0));
   assert_full_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == ALL_IN) |-> (irq_o == '0));
   assert_pend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_pend && hit_w == '0) |=> $stable(pend_q));
endmodule

// File: tb/eint_group_ctrl_tb_top.sv
module eint_group_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] pins = '0;
   logic        we = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int checks = 0;
   int fails  = 0;
   string cur_tag = "R12";

   always #10 clk = ~clk;

   eint_group_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

   // behavioural reference model
   bit [27:0] m_s1, m_s2, m_prv, m_pend, m_mask;
   bit [31:0] m_cfg0, m_cfg1;

   function automatic int field_of(int i);
      if (i < 16) return int'((m_cfg0 >> ((i / 2) * 4)) & 32'h7);
      return int'((m_cfg1 >> (((i - 16) / 2) * 4)) & 32'h7);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prv = '0; m_pend = '0;
         m_mask = 28'hFFFFFFF; m_cfg0 = '0; m_cfg1 = '0;
      end else begin
         bit [27:0] hitv;
         bit [27:0] clr;
         for (int i = 0; i < 28; i++) begin
            bit c, p;
            c = m_s2[i];
            p = m_prv[i];
            case (field_of(i))
               0:       hitv[i] = !c;
               1:       hitv[i] = c;
               2, 3:    hitv[i] = p && !c;
               4, 5:    hitv[i] = !p && c;
               default: hitv[i] = p != c;
            endcase
         end
         clr = (we && addr == 2'd3) ? wdata[27:0] : 28'h0;
         m_pend = (m_pend & ~clr) | hitv;
         m_prv = m_s2;
         m_s2 = m_s1;
         m_s1 = pins;
         if (we) begin
            case (addr)
               2'd0: m_cfg0 = wdata & 32'h77777777;
               2'd1: m_cfg1 = wdata & 32'h00777777;
               2'd2: m_mask = wdata[27:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic compare_all();
      bit [27:0] act;
      bit [3:0]  eirq;
      bit [31:0] erd;
      act = m_pend & ~m_mask;
      eirq = {|act[27:20], |act[19:12], |act[11:4], |act[3:0]};
      case (addr)
         2'd0:    erd = m_cfg0;
         2'd1:    erd = m_cfg1;
         2'd2:    erd = {4'h0, m_mask};
         default: erd = {4'h0, m_pend};
      endcase
      check({"R10 summary lines, phase ", cur_tag}, {28'h0, irq}, {28'h0, eirq});
      check({(addr == 2'd3) ? "R11" : (addr == 2'd2) ? "R9" : "R2", " readback, phase ", cur_tag},
            rdata, erd);
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      tick();
      we = 1'b0;
   endtask

   task automatic rd(logic [1:0] a);
      addr = a;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      rd(2'd2); check("R12 mask after reset", rdata, 32'h0FFFFFFF);
      rd(2'd0); check("R12 trigger word 0 after reset", rdata, 32'h0);
      rd(2'd1); check("R12 trigger word 1 after reset", rdata, 32'h0);

      // R1 R2 R3 field packing and unused bits
      cur_tag = "R2";
      wr(2'd0, 32'hFFFFFFFF); check("R2 trigger word 0 all ones", rdata, 32'h77777777);
      wr(2'd1, 32'hFFFFFFFF); check("R2 trigger word 1 all ones", rdata, 32'h00777777);
      wr(2'd2, 32'hFFFFFFFF); check("R1 mask upper bits", rdata, 32'h0FFFFFFF);
      wr(2'd3, 32'hFFFFFFFF); check("R1 pending upper bits", rdata & 32'hF0000000, 32'h0);
      cur_tag = "R3";
      wr(2'd1, 32'h00000500); check("R3 field of pins 20/21", rdata, 32'h00000500);

      // R6 latency: pin 5 rising edge, field 2 (bits 10:8) = 100
      cur_tag = "R6";
      wr(2'd0, 32'h00000400);
      wr(2'd3, 32'h00000020);
      addr = 2'd3;
      tick(); check("R6 pin5 idle", rdata & 32'h20, 32'h0);
      pins[5] = 1'b1;
      tick(); check("R6 after 1 edge", rdata & 32'h20, 32'h0);
      tick(); check("R6 after 2 edges", rdata & 32'h20, 32'h0);
      tick(); check("R6 after 3 edges", rdata & 32'h20, 32'h20);
      cur_tag = "R5";
      wr(2'd3, 32'h00000020); check("R5 single edge clears", rdata & 32'h20, 32'h0);
      repeat (4) tick();
      check("R5 edge does not re-arm", rdata & 32'h20, 32'h0);
      pins[5] = 1'b0;

      // R7 level re-arm, R4 high level on pin 0
      cur_tag = "R7";
      wr(2'd0, 32'h00000001);
      pins[0] = 1'b1;
      repeat (4) tick();
      addr = 2'd3; tick();
      check("R4 high level pending", rdata & 32'h1, 32'h1);
      wr(2'd3, 32'h00000001); check("R7 clear while level held", rdata & 32'h1, 32'h1);
      pins[0] = 1'b0;
      repeat (4) tick();
      check("R7 flag kept until cleared", rdata & 32'h1, 32'h1);
      wr(2'd3, 32'h00000001); check("R7 clear after level gone", rdata & 32'h1, 32'h0);
      cur_tag = "R8";
      wr(2'd3, 32'h00000000); check("R8 write zero keeps flags", rdata & 32'h0000FFFC, 32'h0000FFFC);

      // R9 R11 mask gating versus raw read
      cur_tag = "R9";
      wr(2'd2, 32'hFFFFFFFF);
      addr = 2'd3; tick();
      check("R11 raw pending under full mask", rdata & 32'h0000FFFC, 32'h0000FFFC);
      check("R9 summary blocked", {28'h0, irq}, 32'h0);
      wr(2'd2, 32'hFFFFFFF7); tick();
      check("R10 group 0 raised by pin 3", {28'h0, irq}, 32'h1);

      // randomised phases under the model
      for (int p = 0; p < 4; p++) begin
         cur_tag = (p == 0) ? "R4" : (p == 1) ? "R5" : (p == 2) ? "R8" : "R10";
         wr(2'd0, (p % 2 == 0) ? 32'h76543210 : 32'h01234567);
         wr(2'd1, (p < 2) ? 32'h00654321 : 32'h00107654);
         wr(2'd2, (p == 3) ? 32'h0 : $urandom);
         for (int c = 0; c < 1500; c++) begin
            pins = pins ^ 28'($urandom & $urandom & $urandom);
            if ($urandom_range(0, 7) == 0) wr(2'd3, $urandom);
            else if ($urandom_range(0, 31) == 0) wr(2'd2, $urandom);
            else rd(2'($urandom_range(0, 3)));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule